// File: doc/BRIEF.md
# Cross-Domain Register Write Bridge

This block sits between a fast register bus and a bank of configuration registers clocked by a separate, much slower clock. Each write to a slow-domain register is carried across the clock boundary with a toggle handshake. The bus side holds the address and data stable, flips a request toggle, and waits until an acknowledge toggle returns from the slow side through a two-flop synchronizer. While a write is in flight, a ready flag in the status register reads 0. When the slow register has taken the value, the flag returns to 1. Only one write may be in flight. A write to a slow-domain register while the flag is 0 is discarded and sets a sticky error flag.

Reads never wait. The bus side keeps a shadow copy of every slow register and updates it in the same cycle the write is seen to land. A read of any address therefore returns data on the next bus cycle, even when reads are issued on every cycle. Each landed write also sets a sticky "write done" raw interrupt bit. That bit is ANDed with a mask bit to drive the interrupt line and the masked-status register, and it is cleared by writing 1 to it.

The register map on the bus uses the addresses below and above the slow bank:
- Addresses 0 to NREG-1 select the slow registers.
- Address NREG is STAT. Bit 0 is the read-only ready flag. Bit 1 is the error flag, cleared by writing 1 to it.
- Address NREG+1 is RAW. Bit 0 is the write-done bit, cleared by writing 1 to it.
- Address NREG+2 is MASK. Bit 0 is read/write.
- Address NREG+3 is MIS. Bit 0 is read-only and equals RAW AND MASK.
- All other addresses read 0.

Top module: `xdom_wr_bridge`

## Requirements
- R1: After reset, STAT reads 1 (ready=1, error=0), RAW, MASK and MIS read 0, `irq_o` is 0, and every slow register and its shadow read 0.
- R2: A write to a slow-register address (below NREG) accepted while ready=1 clears the ready flag on the next bus cycle, so a STAT read issued right after it returns bit 0 = 0.
- R3: The ready flag returns to 1 only after the addressed slow register (visible on `slow_regs_o`, register k at bits k*DW and up) holds the written data.
- R4: A write to a slow-register address while ready=0 is dropped: no slow register or shadow changes. It sets STAT bit 1 on the next cycle.
- R5: The error flag is sticky. Writing STAT with bit 1 = 1 clears it, and writing with bit 1 = 0 leaves it. Writes to STAT, RAW and MASK take effect whether or not ready is 1.
- R6: A read strobe at any address yields `bus_rdata` on the next bus cycle. Reads on consecutive cycles each return their own address's value, with no stall.
- R7: Once ready has returned to 1, a read of the written slow-register address returns the written data.
- R8: Each landed write sets RAW bit 0, which stays set until a write to RAW with bit 0 = 1 clears it. A landing in the same cycle as such a clear wins.
- R9: MIS bit 0 reads RAW AND MASK. `irq_o` is a register that follows RAW AND MASK one bus cycle later, so `irq_o` is 1 only if MASK was 1 in the previous cycle.
- R10: Reads of addresses NREG+4 and above return 0.
- R11: The request toggle changes only on a cycle where ready was 1, so at most one write is ever in flight across the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| slow_clk | input | 1 | Slow register-domain clock |
| slow_rst | input | 1 | Synchronous active-high reset, slow domain |
| bus_addr | input | AW | Register address |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_wdata | input | DW | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DW | Read data, valid the cycle after `bus_rd` |
| irq_o | output | 1 | Masked write-done interrupt |
| slow_regs_o | output | NREG*DW | Slow-domain register bank, register k at bits k*DW and up |

## Verification
The checker watches the bus domain on every cycle for four things:
- An accepted write clears ready.
- A write while busy raises the error flag.
- The request toggle moves only when ready was set.
- Ready never rises before the addressed slow register holds the held data.

It also ties the interrupt to the mask and the STAT read data to the ready flag. Several behaviours only the bench scenarios can show:
- A dropped write really leaves the other registers untouched.
- The shadow returns the right value after landing.
- Back-to-back reads stream without a stall.
- Clearing by writing 1 acts only on the intended bit.

These are shown across a sweep of every slow register with several data patterns.

// File: rtl/xwb_pkg.sv
package xwb_pkg;
  // Local register offsets above the slow bank
  localparam int unsigned OFF_STAT = 0;
  localparam int unsigned OFF_RAW  = 1;
  localparam int unsigned OFF_MASK = 2;
  localparam int unsigned OFF_MIS  = 3;
  localparam int unsigned N_LOCAL  = 4;

  // STAT bit positions
  localparam int unsigned STAT_RDY = 0;
  localparam int unsigned STAT_ERR = 1;

  typedef enum logic [2:0] {
    SEL_SLOW,
    SEL_STAT,
    SEL_RAW,
    SEL_MASK,
    SEL_MIS,
    SEL_NONE
  } sel_e;
endpackage

// File: rtl/xwb_sync.sv
module xwb_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/xwb_slow_side.sv
module xwb_slow_side #(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 8,
  localparam int unsigned IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_tog_a,
  input  logic [IW-1:0]      hold_addr_a,
  input  logic [DW-1:0]      hold_data_a,
  output logic               ack_tog,
  output logic [NREG*DW-1:0] regs_flat
);
  logic req_s;
  logic req_seen;
  logic commit;

  xwb_sync #(.W(1), .STAGES(2)) i_req_sync (
    .clk (clk),
    .rst (rst),
    .d   (req_tog_a),
    .q   (req_s)
  );

  // A new request is pending when the synchronized toggle differs from the last one handled
  assign commit = req_s ^ req_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_seen <= 1'b0;
      ack_tog  <= 1'b0;
    end else begin
      req_seen <= req_s;
      if (commit) ack_tog <= ~ack_tog;
    end
  end

  // The bus side holds address and data stable until the acknowledge returns
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] r;
    always_ff @(posedge clk) begin
      if (rst) r <= '0;
      else if (commit && hold_addr_a == IW'(g)) r <= hold_data_a;
    end
    assign regs_flat[g*DW +: DW] = r;
  end
endmodule

// File: rtl/xwb_bus_side.sv
module xwb_bus_side
  import xwb_pkg::*;
#(
  parameter int unsigned AW   = 4,
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 8,
  localparam int unsigned IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  output logic [DW-1:0] rdata,
  output logic          irq,
  input  logic          ack_s,
  output logic          req_tog,
  output logic [IW-1:0] hold_addr,
  output logic [DW-1:0] hold_data,
  output logic          ready,
  output logic          err,
  output logic          mask
);
  localparam logic [AW-1:0] A_BANK_END = AW'(NREG);
  localparam logic [AW-1:0] A_STAT     = AW'(NREG + OFF_STAT);
  localparam logic [AW-1:0] A_RAW      = AW'(NREG + OFF_RAW);
  localparam logic [AW-1:0] A_MASK     = AW'(NREG + OFF_MASK);
  localparam logic [AW-1:0] A_MIS      = AW'(NREG + OFF_MIS);

  logic [DW-1:0] shadow [NREG];
  logic          raw_q;
  logic          irq_q;
  logic [DW-1:0] rd_mux;
  sel_e          sel;
  logic          accept;
  logic          drop;
  logic          land;

  always_comb begin
    if (addr < A_BANK_END)  sel = SEL_SLOW;
    else if (addr == A_STAT) sel = SEL_STAT;
    else if (addr == A_RAW)  sel = SEL_RAW;
    else if (addr == A_MASK) sel = SEL_MASK;
    else if (addr == A_MIS)  sel = SEL_MIS;
    else                     sel = SEL_NONE;
  end

  assign accept = wr && (sel == SEL_SLOW) && ready;
  assign drop   = wr && (sel == SEL_SLOW) && !ready;
  // The returned acknowledge matches the request once the slow side has committed
  assign land   = !ready && (ack_s == req_tog);

  always_ff @(posedge clk) begin
    if (rst) begin
      ready     <= 1'b1;
      req_tog   <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
    end else if (accept) begin
      ready     <= 1'b0;
      req_tog   <= ~req_tog;
      hold_addr <= addr[IW-1:0];
      hold_data <= wdata;
    end else if (land) begin
      ready     <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err   <= 1'b0;
      raw_q <= 1'b0;
      mask  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (drop) err <= 1'b1;
      else if (wr && sel == SEL_STAT && wdata[STAT_ERR]) err <= 1'b0;

      if (land) raw_q <= 1'b1;
      else if (wr && sel == SEL_RAW && wdata[0]) raw_q <= 1'b0;

      if (wr && sel == SEL_MASK) mask <= wdata[0];

      irq_q <= raw_q & mask;
    end
  end

  // Shadow copy: one write port (on landing), one read port (bus read)
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) shadow[i] <= '0;
    end else if (land) begin
      shadow[hold_addr] <= hold_data;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_SLOW: rd_mux = shadow[addr[IW-1:0]];
      SEL_STAT: begin
        rd_mux[STAT_RDY] = ready;
        rd_mux[STAT_ERR] = err;
      end
      SEL_RAW:  rd_mux[0] = raw_q;
      SEL_MASK: rd_mux[0] = mask;
      SEL_MIS:  rd_mux[0] = raw_q & mask;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end

  assign irq = irq_q;
endmodule

// File: rtl/xdom_wr_bridge.sv
module xdom_wr_bridge #(
  parameter int unsigned AW   = 4,
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 8,
  localparam int unsigned IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               bus_clk,
  input  logic               bus_rst,
  input  logic               slow_clk,
  input  logic               slow_rst,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_wr,
  input  logic [DW-1:0]      bus_wdata,
  input  logic               bus_rd,
  output logic [DW-1:0]      bus_rdata,
  output logic               irq_o,
  output logic [NREG*DW-1:0] slow_regs_o
);
  logic          req_tog_w;
  logic          ack_tog_w;
  logic          ack_s_w;
  logic [IW-1:0] hold_addr_w;
  logic [DW-1:0] hold_data_w;
  logic          ready_w;
  logic          err_w;
  logic          mask_w;

  xwb_bus_side #(.AW(AW), .DW(DW), .NREG(NREG)) i_bus (
    .clk       (bus_clk),
    .rst       (bus_rst),
    .addr      (bus_addr),
    .wr        (bus_wr),
    .wdata     (bus_wdata),
    .rd        (bus_rd),
    .rdata     (bus_rdata),
    .irq       (irq_o),
    .ack_s     (ack_s_w),
    .req_tog   (req_tog_w),
    .hold_addr (hold_addr_w),
    .hold_data (hold_data_w),
    .ready     (ready_w),
    .err       (err_w),
    .mask      (mask_w)
  );

  xwb_sync #(.W(1), .STAGES(2)) i_ack_sync (
    .clk (bus_clk),
    .rst (bus_rst),
    .d   (ack_tog_w),
    .q   (ack_s_w)
  );

  xwb_slow_side #(.DW(DW), .NREG(NREG)) i_slow (
    .clk         (slow_clk),
    .rst         (slow_rst),
    .req_tog_a   (req_tog_w),
    .hold_addr_a (hold_addr_w),
    .hold_data_a (hold_data_w),
    .ack_tog     (ack_tog_w),
    .regs_flat   (slow_regs_o)
  );
endmodule

// File: rtl/xwb_chk.sv
module xwb_chk #(
  parameter int unsigned AW   = 4,
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 8,
  localparam int unsigned IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input logic               bus_clk,
  input logic               bus_rst,
  input logic [AW-1:0]      bus_addr,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [DW-1:0]      bus_rdata,
  input logic               irq_o,
  input logic [NREG*DW-1:0] slow_regs_o,
  input logic               req_tog_w,
  input logic [IW-1:0]      hold_addr_w,
  input logic [DW-1:0]      hold_data_w,
  input logic               ready_w,
  input logic               err_w,
  input logic               mask_w
);
  localparam logic [AW-1:0] A_END  = AW'(NREG);
  localparam logic [AW-1:0] A_STAT = AW'(NREG);

  // R2
  wr_clears_rdy_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (bus_wr && bus_addr < A_END && ready_w) |=> !ready_w);

  // R4
  busy_wr_err_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (bus_wr && bus_addr < A_END && !ready_w) |=> err_w);

  // R11
  one_inflight_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (req_tog_w != $past(req_tog_w)) |-> $past(ready_w));

  // R3
  landed_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    $rose(ready_w) |-> (slow_regs_o[hold_addr_w*DW +: DW] == hold_data_w));

  // R6
  stat_rd_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (bus_rd && bus_addr == A_STAT) |=> (bus_rdata[0] == $past(ready_w)));

  // R9
  irq_mask_chk: assert property (@(posedge bus_clk) disable iff (bus_rst)
    irq_o |-> $past(mask_w));
endmodule

bind xdom_wr_bridge xwb_chk #(.AW(AW), .DW(DW), .NREG(NREG)) i_xwb_chk (
  .bus_clk     (bus_clk),
  .bus_rst     (bus_rst),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_rdata   (bus_rdata),
  .irq_o       (irq_o),
  .slow_regs_o (slow_regs_o),
  .req_tog_w   (req_tog_w),
  .hold_addr_w (hold_addr_w),
  .hold_data_w (hold_data_w),
  .ready_w     (ready_w),
  .err_w       (err_w),
  .mask_w      (mask_w)
);

// File: tb/test_xdom_wr_bridge.sv
module test_xdom_wr_bridge;
  localparam int AW = 4, DW = 16, NREG = 8;
  localparam logic [AW-1:0] A_STAT = AW'(NREG), A_RAW = AW'(NREG+1),
                            A_MASK = AW'(NREG+2), A_MIS = AW'(NREG+3);

  logic bus_clk = 0, slow_clk = 0, bus_rst = 1, slow_rst = 1;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic irq_o;
  logic [NREG*DW-1:0] slow_regs_o;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic [DW-1:0] model [NREG];

  always #4 bus_clk = ~bus_clk;
  always #23 slow_clk = ~slow_clk;

  xdom_wr_bridge #(.AW(AW), .DW(DW), .NREG(NREG)) i_xdom_wr_bridge (
    .bus_clk(bus_clk), .bus_rst(bus_rst), .slow_clk(slow_clk), .slow_rst(slow_rst),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .slow_regs_o(slow_regs_o));

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge bus_clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge bus_clk); bus_wr = 0;
  endtask

  task automatic do_rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge bus_clk); bus_addr = a; bus_rd = 1;
    @(negedge bus_clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic wait_ready(string req);
    logic [DW-1:0] s;
    int tries = 0;
    do begin do_rd(A_STAT, s); tries++; end while (!s[0] && tries < 300);
    check(req, {15'd0, s[0]}, 16'd1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge bus_clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] r;
    logic [DW-1:0] d;
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (4) @(posedge slow_clk);
    @(negedge bus_clk); bus_rst = 0; slow_rst = 0;

    // R1 reset state
    do_rd(A_STAT, r); check("R1 stat", r, 16'h0001);
    do_rd(A_RAW, r);  check("R1 raw", r, 16'h0000);
    do_rd(A_MASK, r); check("R1 mask", r, 16'h0000);
    do_rd(A_MIS, r);  check("R1 mis", r, 16'h0000);
    check("R1 irq", {15'd0, irq_o}, 16'd0);
    for (int i = 0; i < NREG; i++) begin
      do_rd(AW'(i), r); check("R1 shadow", r, 16'h0000);
      check("R1 slow", slow_regs_o[i*DW +: DW], 16'h0000);
    end

    // R10 unmapped addresses
    for (int a = NREG + 4; a < 16; a++) begin
      do_rd(AW'(a), r); check("R10 unmapped", r, 16'h0000);
    end

    // Sweep: every slow register, several patterns
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < NREG; i++) begin
        d = DW'((i + 1) * 4099 + p * 12345 + 1);
        do_wr(AW'(i), d);
        model[i] = d;
        do_rd(A_STAT, r); check("R2 ready cleared", {15'd0, r[0]}, 16'd0);
        wait_ready("R3 ready returns");
        check("R3 slow holds data", slow_regs_o[i*DW +: DW], d);
        do_rd(AW'(i), r); check("R7 shadow", r, d);
        do_rd(A_RAW, r);  check("R8 raw set", r, 16'h0001);
        do_wr(A_RAW, 16'h0000);
        do_rd(A_RAW, r);  check("R8 raw kept on 0 write", r, 16'h0001);
        do_wr(A_RAW, 16'h0001);
        do_rd(A_RAW, r);  check("R8 raw cleared", r, 16'h0000);
      end
    end

    // R4 / R11: second write while busy is dropped
    do_wr(AW'(0), 16'hA5A5); model[0] = 16'hA5A5;
    do_wr(AW'(1), 16'h5A5A);
    do_rd(A_STAT, r); check("R4 err set", r, 16'h0002);
    wait_ready("R11 first write completes");
    check("R4 dropped slow", slow_regs_o[1*DW +: DW], model[1]);
    do_rd(AW'(1), r); check("R4 dropped shadow", r, model[1]);
    check("R11 first landed", slow_regs_o[0 +: DW], 16'hA5A5);

    // R5 sticky error, W1C, local writes while busy
    do_wr(A_STAT, 16'h0000);
    do_rd(A_STAT, r); check("R5 err sticky", r, 16'h0003);
    do_wr(A_STAT, 16'h0002);
    do_rd(A_STAT, r); check("R5 err cleared", r, 16'h0001);
    do_wr(A_RAW, 16'h0001);
    do_wr(AW'(2), 16'h1234); model[2] = 16'h1234;
    do_wr(A_MASK, 16'h0001);
    do_rd(A_MASK, r); check("R5 mask while busy", r, 16'h0001);
    do_rd(A_STAT, r); check("R5 no err from local write", r, 16'h0000);

    // R9 interrupt with mask set
    wait_ready("R9 write lands");
    repeat (2) @(negedge bus_clk);
    check("R9 irq on", {15'd0, irq_o}, 16'd1);
    do_rd(A_MIS, r); check("R9 mis on", r, 16'h0001);
    do_wr(A_RAW, 16'h0001);
    repeat (2) @(negedge bus_clk);
    check("R9 irq off", {15'd0, irq_o}, 16'd0);
    do_wr(A_MASK, 16'h0000);
    do_wr(AW'(3), 16'hBEEF); model[3] = 16'hBEEF;
    wait_ready("R9 masked write lands");
    repeat (2) @(negedge bus_clk);
    check("R9 irq masked", {15'd0, irq_o}, 16'd0);
    do_rd(A_MIS, r); check("R9 mis masked", r, 16'h0000);
    do_rd(A_RAW, r); check("R8 raw under mask", r, 16'h0001);

    // R6 back-to-back reads, one per cycle
    @(negedge bus_clk); bus_addr = AW'(0); bus_rd = 1;
    for (int k = 0; k < NREG; k++) begin
      @(negedge bus_clk);
      check("R6 streamed read", bus_rdata, model[k]);
      bus_addr = (k + 1 < NREG) ? AW'(k + 1) : A_STAT;
    end
    @(negedge bus_clk); bus_rd = 0;
    check("R6 streamed stat", bus_rdata, 16'h0001);

    finish_run();
  end
endmodule